// File: doc/BRIEF.md
# SPI Slave Receive Engine with Overrun and Abort Detection

This block is the receive half of an SPI slave that runs in the system clock domain. The serial clock, the active-low select and the data line each pass through two-flop synchronizers. The engine samples data on each rising serial clock edge while select is low. After eight bits it moves the finished character into a holding register and raises a receive-full flag. Software reads the character with a read strobe, and that strobe lowers the flag.

The block detects two error conditions. An overrun occurs when a character completes while the previous one has not been read yet. The held character is then kept and the new one is dropped. An abort occurs when select is released part-way through a character. The partial character is discarded and the bit counter returns to zero. Each error has a sticky flag that software clears by writing a one to its bit on the clear port. When a set and a clear reach a flag in the same cycle, the set takes effect.

Top module: `spi_rx_slave`

## Requirements
- R1: After reset, the data output, receive-full, overrun and abort flags are all zero.
- R2: While select is low, the engine samples the data line on rising serial clock edges, most significant bit first. After the eighth bit it places the character on the data output and sets receive-full.
- R3: A read strobe clears receive-full. The data output keeps the held character.
- R4: If a character completes while receive-full is set, the overrun flag is set. The data output keeps the earlier character and the new character is discarded.
- R5: On the clear port, bit 0 clears the overrun flag and bit 1 clears the abort flag. A zero in either bit leaves its flag unchanged.
- R6: If select rises after one to seven bits of a character, the abort flag is set and the partial bits are discarded. The next character after select falls again is assembled from a fresh first bit.
- R7: If select rises when no bits of a character are pending, the abort flag is not set.
- R8: If a flag set condition and a clear-port write for that flag occur in the same cycle, the flag ends up set.
- R9: A character completing in the same cycle as a read strobe is judged against receive-full as it was before the read. If the flag was set, overrun is set and the old data is kept while the read clears receive-full. If the flag was clear, the new character is loaded and receive-full stays set.
- R10: Serial clock edges while select is high change neither the flags nor the bit position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master (asynchronous, idles low) |
| ss_n_i | input | 1 | Active-low slave select (asynchronous) |
| mosi_i | input | 1 | Serial data from the master (asynchronous) |
| rd_strobe_i | input | 1 | One-cycle read of the receive data register |
| w1c_i | input | 2 | Write-one-to-clear: bit 0 overrun, bit 1 abort |
| rx_data_o | output | 8 | Held received character |
| rx_full_o | output | 1 | Receive-full flag |
| rx_overrun_o | output | 1 | Sticky overrun flag |
| rx_abort_o | output | 1 | Sticky abort flag |

## Verification
Several functions can act in the same cycle: a character completing at the same moment as a register read, and an error being raised at the same moment as its clear write. The bench counts the synchronizer and edge-detect stages from the serial pin change to the status update. It then drives the read strobe or the clear bit on exactly that status-update cycle. The outcome is judged against the priority in R8 and R9: the state of receive-full before the read decides between load and overrun, and a set beats a clear. These coincidences are run with the receiver both empty and full. The abort coincidence is run as well.

// File: rtl/spi_rx_pkg.sv
// Package: shared widths and clear-port bit positions for the SPI slave receiver.
// Assumes: fixed 8-bit characters; the clear-port layout is fixed by these constants.
package spi_rx_pkg;
    localparam int unsigned SPI_CHAR_W   = 8;
    localparam int unsigned SPI_SYNC_LEN = 2;
    localparam int unsigned W1C_W        = 2;
    localparam int unsigned W1C_OVR_BIT  = 0;
    localparam int unsigned W1C_ABT_BIT  = 1;

    typedef logic [SPI_CHAR_W-1:0] spi_char_t;
endpackage

// File: rtl/spi_rx_sync.sv
// Module: multi-bit level synchronizer, one independent chain per bit.
// Assumes: STAGES >= 2; every input is a slow level relative to clk; reset value set per bit.
module spi_rx_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int unsigned CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain_q;

    // Shift the raw inputs through STAGES flop ranks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d_i};
        end
    end

    assign q_o = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/spi_rx_shifter.sv
// Module: serial shift engine. Detects rising serial clock edges and select release,
// assembles MSB-first characters, and emits one-cycle done / abort pulses.
// Assumes: synchronized inputs; mode 0 timing (sample on rising edge, clock idles low).
module spi_rx_shifter #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s_i,
    input  logic              ss_n_s_i,
    input  logic              mosi_s_i,
    output logic [CHAR_W-1:0] char_o,
    output logic              done_o,
    output logic              abort_o
);
    localparam int unsigned CNT_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CHAR_W - 1);

    logic              sck_q;
    logic              ss_n_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [CHAR_W-1:0] shreg_q;
    logic [CHAR_W-1:0] char_q;
    logic              done_q;
    logic              abort_q;

    logic              sck_rise;
    logic              selected;
    logic              ss_release;
    logic              at_last_bit;
    logic [CHAR_W-1:0] shreg_next;

    // Edge and boundary decode on the synchronized signals.
    always_comb begin
        sck_rise    = sck_s_i & ~sck_q;
        selected    = ~ss_n_s_i;
        ss_release  = ss_n_s_i & ~ss_n_q;
        at_last_bit = (bit_cnt_q == LAST_IDX);
        shreg_next  = {shreg_q[CHAR_W-2:0], mosi_s_i};
    end

    // Keep previous samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            ss_n_q <= 1'b1;
        end else begin
            sck_q  <= sck_s_i;
            ss_n_q <= ss_n_s_i;
        end
    end

    // Bit counter and shift register; both cleared while select is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shreg_q   <= '0;
        end else if (!selected) begin
            bit_cnt_q <= '0;
            shreg_q   <= '0;
        end else if (sck_rise) begin
            shreg_q   <= shreg_next;
            bit_cnt_q <= at_last_bit ? '0 : bit_cnt_q + CNT_W'(1);
        end
    end

    // Completion pulse with the finished character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            char_q <= '0;
        end else begin
            done_q <= selected & sck_rise & at_last_bit;
            if (selected && sck_rise && at_last_bit) begin
                char_q <= shreg_next;
            end
        end
    end

    // Abort pulse when select releases with a partial character pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_q <= 1'b0;
        end else begin
            abort_q <= ss_release & (bit_cnt_q != '0);
        end
    end

    assign char_o  = char_q;
    assign done_o  = done_q;
    assign abort_o = abort_q;

    // R6
    done_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && abort_q));

    // R10
    idle_count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_s_i |=> (bit_cnt_q == '0));

    // R7
    clean_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_release && bit_cnt_q == '0) |=> !abort_q);
endmodule

// File: rtl/spi_rx_status.sv
// Module: receive data register and status flags (full, overrun, abort).
// Assumes: done_i / abort_i are single-cycle pulses; set has priority over clear,
// and a completion is judged against the full flag held before any same-cycle read.
module spi_rx_status #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [CHAR_W-1:0] char_i,
    input  logic              abort_i,
    input  logic              rd_i,
    input  logic              clr_ovr_i,
    input  logic              clr_abt_i,
    output logic [CHAR_W-1:0] data_o,
    output logic              full_o,
    output logic              ovr_o,
    output logic              abt_o
);
    logic [CHAR_W-1:0] data_q;
    logic              full_q;
    logic              ovr_q;
    logic              abt_q;
    logic              accept;
    logic              collide;

    // Classify a completion against the current full flag.
    always_comb begin
        accept  = done_i & ~full_q;
        collide = done_i &  full_q;
    end

    // Hold the accepted character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (accept) begin
            data_q <= char_i;
        end
    end

    // Receive-full: set on accept, else cleared by read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
        end else if (accept) begin
            full_q <= 1'b1;
        end else if (rd_i) begin
            full_q <= 1'b0;
        end
    end

    // Sticky overrun and abort flags, set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            abt_q <= 1'b0;
        end else begin
            if (collide) begin
                ovr_q <= 1'b1;
            end else if (clr_ovr_i) begin
                ovr_q <= 1'b0;
            end
            if (abort_i) begin
                abt_q <= 1'b1;
            end else if (clr_abt_i) begin
                abt_q <= 1'b0;
            end
        end
    end

    assign data_o = data_q;
    assign full_o = full_q;
    assign ovr_o  = ovr_q;
    assign abt_o  = abt_q;

    // R4
    overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && full_q) |=> (ovr_q && $stable(data_q)));

    // R2
    accept_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !full_q) |=> full_q);

    // R3
    read_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !done_i) |=> (!full_q && $stable(data_q)));

    // R8
    abort_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> abt_q);
endmodule

// File: rtl/spi_rx_slave.sv
// Module: top of the SPI slave receive engine. Synchronizes the pins, shifts
// characters in and keeps the receive register with its status flags.
// Assumes: mode 0, 8-bit characters, serial clock well below clk/4.
module spi_rx_slave
    import spi_rx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sck_i,
    input  logic                  ss_n_i,
    input  logic                  mosi_i,
    input  logic                  rd_strobe_i,
    input  logic [W1C_W-1:0]      w1c_i,
    output logic [SPI_CHAR_W-1:0] rx_data_o,
    output logic                  rx_full_o,
    output logic                  rx_overrun_o,
    output logic                  rx_abort_o
);
    // Synchronizer bit order: {sck, ss_n, mosi}; select resets inactive.
    localparam logic [2:0] PIN_RST = 3'b010;

    logic [2:0] pins_s;
    spi_char_t  char_w;
    logic       done_w;
    logic       abort_w;

    spi_rx_sync #(
        .WIDTH  (3),
        .STAGES (SPI_SYNC_LEN),
        .RST_VAL(PIN_RST)
    ) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({sck_i, ss_n_i, mosi_i}),
        .q_o  (pins_s)
    );

    spi_rx_shifter #(
        .CHAR_W(SPI_CHAR_W)
    ) shifter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s_i (pins_s[2]),
        .ss_n_s_i(pins_s[1]),
        .mosi_s_i(pins_s[0]),
        .char_o  (char_w),
        .done_o  (done_w),
        .abort_o (abort_w)
    );

    spi_rx_status #(
        .CHAR_W(SPI_CHAR_W)
    ) status_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (done_w),
        .char_i   (char_w),
        .abort_i  (abort_w),
        .rd_i     (rd_strobe_i),
        .clr_ovr_i(w1c_i[W1C_OVR_BIT]),
        .clr_abt_i(w1c_i[W1C_ABT_BIT]),
        .data_o   (rx_data_o),
        .full_o   (rx_full_o),
        .ovr_o    (rx_overrun_o),
        .abt_o    (rx_abort_o)
    );

    // R5
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_i[W1C_OVR_BIT] && !(done_w && rx_full_o)) |=> !rx_overrun_o);
endmodule

// File: tb/spi_rx_slave_tb.sv
`timescale 1ns/1ps
module spi_rx_slave_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       ss_n = 1'b1;
    logic       mosi = 1'b0;
    logic       rd = 1'b0;
    logic [1:0] w1c = 2'b00;
    logic [7:0] rx_data;
    logic       rx_full;
    logic       rx_ovr;
    logic       rx_abt;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    spi_rx_slave dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_i       (sck),
        .ss_n_i      (ss_n),
        .mosi_i      (mosi),
        .rd_strobe_i (rd),
        .w1c_i       (w1c),
        .rx_data_o   (rx_data),
        .rx_full_o   (rx_full),
        .rx_overrun_o(rx_ovr),
        .rx_abort_o  (rx_abt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic select(input logic on);
        @(negedge clk);
        ss_n = ~on;
        settle();
    endtask

    // Shift the first nbits of b, MSB first, with full clock periods.
    task automatic shift_bits(input logic [7:0] b, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            mosi = b[7-i];
            repeat (4) @(negedge clk);
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        select(1'b1);
        shift_bits(b, 8);
        select(1'b0);
    endtask

    // Drive rd / w1c on the status-update cycle of a pin change just made at a negedge.
    task automatic hit_status_cycle(input logic r, input logic [1:0] w);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd  = r;
        w1c = w;
        @(negedge clk);
        rd  = 1'b0;
        w1c = 2'b00;
    endtask

    // Send a byte whose final rising edge coincides with r / w.
    task automatic send_byte_hit(input logic [7:0] b, input logic r, input logic [1:0] w);
        select(1'b1);
        shift_bits(b, 7);
        @(negedge clk);
        mosi = b[0];
        repeat (4) @(negedge clk);
        sck = 1'b1;
        hit_status_cycle(r, w);
        repeat (3) @(negedge clk);
        sck = 1'b0;
        select(1'b0);
    endtask

    task automatic do_read();
        @(negedge clk); rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        settle();
    endtask

    task automatic do_clear(input logic [1:0] w);
        @(negedge clk); w1c = w;
        @(negedge clk); w1c = 2'b00;
        settle();
    endtask

    task automatic t_reset();
        chk("R1 data", rx_data, 8'h00);
        chk("R1 full", rx_full, 1'b0);
        chk("R1 ovr", rx_ovr, 1'b0);
        chk("R1 abt", rx_abt, 1'b0);
    endtask

    task automatic t_basic();
        send_byte(8'hA5);
        chk("R2 data", rx_data, 8'hA5);
        chk("R2 full", rx_full, 1'b1);
        chk("R7 no abort on clean release", rx_abt, 1'b0);
        do_read();
        chk("R3 full cleared", rx_full, 1'b0);
        chk("R3 data held", rx_data, 8'hA5);
    endtask

    task automatic t_overrun();
        send_byte(8'h3C);
        send_byte(8'hC3);
        chk("R4 data kept", rx_data, 8'h3C);
        chk("R4 ovr set", rx_ovr, 1'b1);
        chk("R4 full", rx_full, 1'b1);
        do_clear(2'b10);
        chk("R5 abt-bit leaves ovr", rx_ovr, 1'b1);
        do_clear(2'b01);
        chk("R5 ovr cleared", rx_ovr, 1'b0);
        do_read();
    endtask

    task automatic t_abort();
        select(1'b1);
        shift_bits(8'hFF, 3);
        select(1'b0);
        chk("R6 abt set", rx_abt, 1'b1);
        chk("R6 partial discarded", rx_full, 1'b0);
        do_clear(2'b01);
        chk("R5 ovr-bit leaves abt", rx_abt, 1'b1);
        do_clear(2'b10);
        chk("R5 abt cleared", rx_abt, 1'b0);
        send_byte(8'h5A);
        chk("R6 fresh char", rx_data, 8'h5A);
        do_read();
        select(1'b1);
        select(1'b0);
        chk("R7 empty release", rx_abt, 1'b0);
    endtask

    task automatic t_ignore_sck();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); mosi = i[0];
            repeat (4) @(negedge clk); sck = 1'b1;
            repeat (4) @(negedge clk); sck = 1'b0;
        end
        settle();
        chk("R10 full unchanged", rx_full, 1'b0);
        chk("R10 abt unchanged", rx_abt, 1'b0);
        send_byte(8'h81);
        chk("R10 bit position untouched", rx_data, 8'h81);
        chk("R10 no abort", rx_abt, 1'b0);
        do_read();
    endtask

    task automatic t_set_wins();
        select(1'b1);
        shift_bits(8'hC0, 2);
        @(negedge clk);
        ss_n = 1'b1;
        hit_status_cycle(1'b0, 2'b10);
        settle();
        chk("R8 abt set wins", rx_abt, 1'b1);
        do_clear(2'b10);
        send_byte(8'h11);
        send_byte_hit(8'h22, 1'b0, 2'b01);
        chk("R8 ovr set wins", rx_ovr, 1'b1);
        chk("R4 data kept on overrun", rx_data, 8'h11);
        do_clear(2'b01);
        do_read();
    endtask

    task automatic t_coincide();
        send_byte(8'h44);
        send_byte_hit(8'h55, 1'b1, 2'b00);
        chk("R9 full cleared by read", rx_full, 1'b0);
        chk("R9 ovr on full", rx_ovr, 1'b1);
        chk("R9 data kept", rx_data, 8'h44);
        do_clear(2'b01);
        send_byte_hit(8'h66, 1'b1, 2'b00);
        chk("R9 loaded when empty", rx_data, 8'h66);
        chk("R9 full stays set", rx_full, 1'b1);
        chk("R9 no ovr when empty", rx_ovr, 1'b0);
        do_read();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_basic();
        t_overrun();
        t_abort();
        t_ignore_sck();
        t_set_wins();
        t_coincide();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule